// File: doc/BRIEF.md
# DDS Tuning-Word Register Loader

This block takes 16-bit command words, each qualified by a one-cycle valid strobe, and files them into the register set that programs a direct digital synthesis core: a control register, two 28-bit frequency tuning words and two 12-bit phase offsets. The two most significant bits of every word pick its destination. The remaining bits carry either control settings or register data.

Two control bits set how a frequency word is loaded. In paired mode, a 28-bit tuning word is built from two 14-bit writes to the same address, low half first. The new value reaches the output only when the high half arrives. In split mode, each write replaces one 14-bit half, and another control bit picks the upper or lower half. Two more control bits drive the select lines that tell the accumulator core which frequency word and which phase word to use.

Top module: `dds_word_loader`

## Requirements
- R1: After reset every register output, `freq_sel` and `phase_sel` read zero.
- R2: A word presented while `wr_valid` is low changes no output.
- R3: Bits [15:14] select the destination: 00 the control register, 01 frequency word 0, 10 frequency word 1, 11 a phase register.
- R4: A control word stores bits [13:0] into `ctrl_word`. `freq_sel` then equals bit 11 and `phase_sel` equals bit 10.
- R5: With control bit 13 set (paired mode), the first frequency write to an address supplies the low 14 bits and the second write to the same address supplies the high 14 bits. The pair 0x4000, 0x7FFF after control word 0x2000 yields frequency word 0 = 0xFFFC000.
- R6: In paired mode the first write of a pair leaves the frequency output unchanged, so a half-built value is never visible.
- R7: In paired mode, a frequency write to the other address while a low half is pending starts a new pair there. A control word discards a pending low half.
- R8: With control bit 13 clear (split mode), a frequency write replaces bits [13:0] when control bit 12 is 0, or bits [27:14] when it is 1, and leaves the other half unchanged.
- R9: A phase write loads bits [11:0] into phase register 0 when bit 13 is 0, or into phase register 1 when bit 13 is 1. Bit 12 is ignored and both frequency words are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Qualifies `wr_word` for one edge |
| wr_word | input | 16 | Command word |
| ctrl_word | output | 14 | Control register contents |
| freq0_q | output | 28 | Frequency tuning word 0 |
| freq1_q | output | 28 | Frequency tuning word 1 |
| phase0_q | output | 12 | Phase offset 0 |
| phase1_q | output | 12 | Phase offset 1 |
| freq_sel | output | 1 | Selects the frequency word used by the core |
| phase_sel | output | 1 | Selects the phase word used by the core |

## Verification
The bench targets the pairing state. It interleaves the two frequency addresses in the middle of a pair: a design that keeps the stale pending low would build a word from two addresses. It inserts a control word between the halves: a design that keeps the pending half would commit a mixed value instead of treating the next write as a new low. A long pseudo-random word sweep, checked against an arithmetic model after every word, catches half-mode writes that disturb the opposite half, phase writes that honour bit 12 or leak into a frequency word, and paired-mode first halves that reach the output early.

// File: rtl/dwl_pkg.sv
// Package dwl_pkg
// Shared widths, control bit positions and the destination code for the
// DDS tuning-word loader. Assumes a 16-bit command word whose top two
// bits choose the destination.
package dwl_pkg;
    localparam int WORD_W   = 16;
    localparam int HALF_W   = 14;
    localparam int FREQ_W   = 2 * HALF_W;
    localparam int PHASE_W  = 12;
    localparam int NUM_FREQ = 2;
    localparam int NUM_PH   = 2;

    // control register bit positions
    localparam int CTL_PAIRED = 13;
    localparam int CTL_UPPER  = 12;
    localparam int CTL_FSEL   = 11;
    localparam int CTL_PSEL   = 10;

    // phase word: bit choosing which phase register
    localparam int PH_PICK = 13;

    typedef enum logic [1:0] {
        DST_CTRL = 2'b00,
        DST_F0   = 2'b01,
        DST_F1   = 2'b10,
        DST_PH   = 2'b11
    } dwl_dest_e;
endpackage

// File: rtl/dwl_decode.sv
// Module dwl_decode
// Turns one qualified command word into write enables for the control
// register, each frequency word and each phase register. Purely
// combinational; assumes valid is already synchronous to the register clock.
module dwl_decode
    import dwl_pkg::*;
(
    input  logic                valid,
    input  logic [WORD_W-1:0]   word,
    output logic                ctrl_we,
    output logic [NUM_FREQ-1:0] freq_we,
    output logic [NUM_PH-1:0]   phase_we,
    output logic [HALF_W-1:0]   payload
);
    dwl_dest_e dest;

    // destination decode from the top two bits
    always_comb begin
        dest        = dwl_dest_e'(word[WORD_W-1:WORD_W-2]);
        ctrl_we     = valid && (dest == DST_CTRL);
        freq_we[0]  = valid && (dest == DST_F0);
        freq_we[1]  = valid && (dest == DST_F1);
        phase_we[0] = valid && (dest == DST_PH) && !word[PH_PICK];
        phase_we[1] = valid && (dest == DST_PH) &&  word[PH_PICK];
        payload     = word[HALF_W-1:0];
    end
endmodule

// File: rtl/dwl_pair_track.sv
// Module dwl_pair_track
// Paired-mode sequencer: holds the low half of a frequency word and the
// address it belongs to until the matching high half arrives. Assumes
// freq_we is one-hot or zero. A control word or a write to the other
// address restarts the pair.
module dwl_pair_track
    import dwl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                paired,
    input  logic                ctrl_we,
    input  logic [NUM_FREQ-1:0] freq_we,
    input  logic [HALF_W-1:0]   data,
    output logic [NUM_FREQ-1:0] commit,
    output logic [HALF_W-1:0]   hold,
    output logic                pending
);
    logic pend_idx;

    // commit strobe when the high half matches the pending address
    for (genvar i = 0; i < NUM_FREQ; i++) begin : g_commit
        assign commit[i] = paired && pending && freq_we[i] && (pend_idx == (i == 1));
    end

    // pending flag, address and held low half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            pend_idx <= 1'b0;
            hold     <= '0;
        end else if (ctrl_we) begin
            pending <= 1'b0;
        end else if (paired && (|freq_we)) begin
            if (|commit) begin
                pending <= 1'b0;
            end else begin
                pending  <= 1'b1;
                pend_idx <= freq_we[1];
                hold     <= data;
            end
        end
    end
endmodule

// File: rtl/dwl_freq_reg.sv
// Module dwl_freq_reg
// One frequency tuning word. In paired mode it loads the full width only
// on a commit strobe; in split mode it replaces the half picked by upper.
// Assumes commit is only raised together with we.
module dwl_freq_reg
    import dwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              paired,
    input  logic              upper,
    input  logic              commit,
    input  logic [HALF_W-1:0] data,
    input  logic [HALF_W-1:0] hold,
    output logic [FREQ_W-1:0] q
);
    // tuning word update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            if (paired) begin
                if (commit) q <= {data, hold};
            end else if (upper) begin
                q[FREQ_W-1:HALF_W] <= data;
            end else begin
                q[HALF_W-1:0] <= data;
            end
        end
    end
endmodule

// File: rtl/dds_word_loader.sv
// Module dds_word_loader
// Top of the DDS register loader: decodes command words, keeps the
// control register and phase offsets, and builds the two frequency
// words. Assumes one word per valid cycle, no back-pressure.
module dds_word_loader
    import dwl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [WORD_W-1:0]  wr_word,
    output logic [HALF_W-1:0]  ctrl_word,
    output logic [FREQ_W-1:0]  freq0_q,
    output logic [FREQ_W-1:0]  freq1_q,
    output logic [PHASE_W-1:0] phase0_q,
    output logic [PHASE_W-1:0] phase1_q,
    output logic               freq_sel,
    output logic               phase_sel
);
    logic                ctrl_we;
    logic [NUM_FREQ-1:0] freq_we;
    logic [NUM_PH-1:0]   phase_we;
    logic [HALF_W-1:0]   payload;
    logic [NUM_FREQ-1:0] commit;
    logic [HALF_W-1:0]   hold;
    logic                pending;
    logic [HALF_W-1:0]   ctrl_q;
    logic [FREQ_W-1:0]   freq_q  [NUM_FREQ];
    logic [PHASE_W-1:0]  phase_q [NUM_PH];

    dwl_decode u_dec (
        .valid    (wr_valid),
        .word     (wr_word),
        .ctrl_we  (ctrl_we),
        .freq_we  (freq_we),
        .phase_we (phase_we),
        .payload  (payload)
    );

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= payload;
    end

    dwl_pair_track u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .paired  (ctrl_q[CTL_PAIRED]),
        .ctrl_we (ctrl_we),
        .freq_we (freq_we),
        .data    (payload),
        .commit  (commit),
        .hold    (hold),
        .pending (pending)
    );

    for (genvar f = 0; f < NUM_FREQ; f++) begin : g_freq
        dwl_freq_reg u_freq (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (freq_we[f]),
            .paired (ctrl_q[CTL_PAIRED]),
            .upper  (ctrl_q[CTL_UPPER]),
            .commit (commit[f]),
            .data   (payload),
            .hold   (hold),
            .q      (freq_q[f])
        );
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        // phase offset register p
        always_ff @(posedge clk) begin
            if (!rst_n)           phase_q[p] <= '0;
            else if (phase_we[p]) phase_q[p] <= payload[PHASE_W-1:0];
        end
    end

    assign ctrl_word = ctrl_q;
    assign freq0_q   = freq_q[0];
    assign freq1_q   = freq_q[1];
    assign phase0_q  = phase_q[0];
    assign phase1_q  = phase_q[1];
    assign freq_sel  = ctrl_q[CTL_FSEL];
    assign phase_sel = ctrl_q[CTL_PSEL];
endmodule

// File: rtl/dwl_checker.sv
// Module dwl_checker
// Temporal properties of dds_word_loader, bound to every instance.
// Assumes rst_n is the synchronous active-low reset of the block.
module dwl_checker
    import dwl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic [WORD_W-1:0]  wr_word,
    input logic [HALF_W-1:0]  ctrl_word,
    input logic [FREQ_W-1:0]  freq0_q,
    input logic [FREQ_W-1:0]  freq1_q,
    input logic [PHASE_W-1:0] phase0_q,
    input logic [PHASE_W-1:0] phase1_q,
    input logic               freq_sel,
    input logic               phase_sel,
    input logic               pending
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(ctrl_word) && $stable(freq0_q) && $stable(freq1_q)
                      && $stable(phase0_q) && $stable(phase1_q));

    // R4
    sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_word[15:14] == 2'b00) |=>
            (freq_sel == $past(wr_word[CTL_FSEL])) && (phase_sel == $past(wr_word[CTL_PSEL])));

    // R6
    no_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_word[15:14] == 2'b01) && ctrl_word[CTL_PAIRED] && !pending
            |=> $stable(freq0_q));

    // R8
    split_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_word[15:14] == 2'b01) && !ctrl_word[CTL_PAIRED] && !ctrl_word[CTL_UPPER]
            |=> (freq0_q[HALF_W-1:0] == $past(wr_word[HALF_W-1:0]))
                && (freq0_q[FREQ_W-1:HALF_W] == $past(freq0_q[FREQ_W-1:HALF_W])));

    // R9
    phase0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_word[15:13] == 3'b110) |=>
            (phase0_q == $past(wr_word[PHASE_W-1:0])) && $stable(phase1_q));

    // R9
    phase_no_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_word[15:14] == 2'b11) |=> $stable(freq0_q) && $stable(freq1_q));
endmodule

bind dds_word_loader dwl_checker u_dwl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_word   (wr_word),
    .ctrl_word (ctrl_word),
    .freq0_q   (freq0_q),
    .freq1_q   (freq1_q),
    .phase0_q  (phase0_q),
    .phase1_q  (phase1_q),
    .freq_sel  (freq_sel),
    .phase_sel (phase_sel),
    .pending   (pending)
);

// File: tb/dds_word_loader_bench.sv
// Bench for dds_word_loader: directed sequences plus a long pseudo-random
// word sweep compared against an arithmetic model of the requirements.
module dds_word_loader_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_word = '0;
    logic [13:0] ctrl_word;
    logic [27:0] freq0_q, freq1_q;
    logic [11:0] phase0_q, phase1_q;
    logic        freq_sel, phase_sel;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [13:0] m_ctrl = '0;
    logic [27:0] m_f [2];
    logic [11:0] m_p [2];
    logic        m_pend = 1'b0;
    logic        m_pidx = 1'b0;
    logic [13:0] m_lo = '0;

    always #(CLK_P/2) clk = ~clk;

    dds_word_loader u_dds_word_loader (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .ctrl_word(ctrl_word), .freq0_q(freq0_q), .freq1_q(freq1_q),
        .phase0_q(phase0_q), .phase1_q(phase1_q),
        .freq_sel(freq_sel), .phase_sel(phase_sel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " ctrl"},   32'(ctrl_word), 32'(m_ctrl));
        check({tag, " freq0"},  32'(freq0_q),   32'(m_f[0]));
        check({tag, " freq1"},  32'(freq1_q),   32'(m_f[1]));
        check({tag, " phase0"}, 32'(phase0_q),  32'(m_p[0]));
        check({tag, " phase1"}, 32'(phase1_q),  32'(m_p[1]));
        check({tag, " fsel"},   32'(freq_sel),  32'(m_ctrl[11]));
        check({tag, " psel"},   32'(phase_sel), 32'(m_ctrl[10]));
    endtask

    // expected effect of one accepted word
    task automatic model_apply(input logic [15:0] w);
        int k;
        case (w[15:14])
            2'b00: begin m_ctrl = w[13:0]; m_pend = 1'b0; end
            2'b11: m_p[w[13] ? 1 : 0] = w[11:0];
            default: begin
                k = w[15] ? 1 : 0;
                if (m_ctrl[13]) begin
                    if (m_pend && (m_pidx == w[15])) begin
                        m_f[k] = 28'(w[13:0]) * 28'd16384 + 28'(m_lo);
                        m_pend = 1'b0;
                    end else begin
                        m_pend = 1'b1; m_pidx = w[15]; m_lo = w[13:0];
                    end
                end else if (m_ctrl[12]) begin
                    m_f[k] = (m_f[k] % 28'd16384) + 28'(w[13:0]) * 28'd16384;
                end else begin
                    m_f[k] = (m_f[k] / 28'd16384) * 28'd16384 + 28'(w[13:0]);
                end
            end
        endcase
    endtask

    // one word with valid high, outputs settle by the following falling edge
    task automatic send(input logic [15:0] w);
        @(negedge clk);
        wr_valid = 1'b1; wr_word = w;
        @(negedge clk);
        wr_valid = 1'b0;
        model_apply(w);
    endtask

    task automatic idle(input logic [15:0] w, input int n);
        @(negedge clk);
        wr_word = w;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        m_f[0] = '0; m_f[1] = '0; m_p[0] = '0; m_p[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("R1");

        // R5 / R6: paired load of 0xFFFC000 into frequency word 0
        send(16'h2000);
        send(16'h4000);
        check("R6 first half hidden", 32'(freq0_q), 32'h0);
        send(16'h7FFF);
        check("R5 paired commit", 32'(freq0_q), 32'h0FFFC000);

        // R8 split mode examples
        send(16'h0000);
        send(16'hBFFF);
        check("R8 freq1 low half", 32'(freq1_q), 32'h00003FFF);
        send(16'h1000);
        send(16'h40FF);
        check("R8 freq0 high half", 32'(freq0_q), 32'h003FC000);
        check_all("R8");

        // R2 ignored while valid low
        idle(16'h7FFF, 5);
        idle(16'h0C00, 3);
        check_all("R2");

        // R4 select bits, all four combinations
        for (int s = 0; s < 4; s++) begin
            send(16'(s) << 10);
            check("R4 fsel", 32'(freq_sel), 32'(s >> 1));
            check("R4 psel", 32'(phase_sel), 32'(s & 1));
        end

        // R9 phase sweep, bit 12 toggled
        for (int v = 0; v < 64; v++) begin
            send(16'hC000 | 16'((v & 1) << 13) | 16'((v & 2) << 11) | 16'(v * 67));
            check_all("R9");
        end

        // R7 address switch mid-pair, then control word mid-pair
        send(16'h2000);
        send(16'h4001);
        send(16'h8002);
        send(16'h8003);
        check("R7 switch freq1", 32'(freq1_q), 32'h0000C002);
        check("R7 switch freq0", 32'(freq0_q), 32'h003FC000);
        send(16'h4005);
        send(16'h2000);
        send(16'h4006);
        check("R7 ctrl discards", 32'(freq0_q), 32'h003FC000);
        send(16'h4007);
        check("R7 new pair", 32'(freq0_q), 32'h0001C006);
        check_all("R7");

        // R3 pseudo-random sweep over all destinations and modes
        lcg = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (lcg[3:0] == 4'd0) idle(lcg[31:16], 1);
            else send(lcg[31:16]);
            check_all("R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule